// File: doc/BRIEF.md
# Endpoint Buffer Allocator

This block gives each physical endpoint of a USB device controller a region of a shared, word-addressed endpoint RAM. Software marks endpoints as wanted in a realize mask, picks one endpoint through an index register, and writes that endpoint's largest packet size in bytes. A per-endpoint double-buffer mask picks one or two buffers. Any write to the realize mask, the size register or the double-buffer mask starts a walk over every endpoint. The walk lays the regions out one after another and then raises a sticky completion bit, which software polls and clears.

Each buffer holds the packet rounded up to whole words plus one header word for the received length. The lowest words of the RAM are kept back for buffer pointers. An endpoint whose region would not fit below the RAM limit is left out, and a sticky error bit is set. A query port lets the token logic read, for one endpoint, its base word, its buffer count, whether it is realized, and whether it may answer tokens. There is no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `ep_alloc`

## Requirements
- R1: Register 0 holds the realize mask, with bit n for endpoint n. A write replaces the mask and a read returns it. A read, OR and write-back sequence keeps every bit that was already set.
- R2: Register 1 selects an endpoint. A write to register 2 stores the size, bits 9:0, for the selected endpoint only, and a read of register 2 returns the size of the selected endpoint.
- R3: An endpoint uses ((size+3)/4+1) words per buffer. It has two buffers when its bit in register 4 is 1 and one buffer otherwise. `q_bufs` gives 1 or 2 for a realized endpoint and 0 for any other.
- R4: Realized endpoints are placed in ascending endpoint order. The first starts at word PTR_WORDS (32), and each later one starts right after the region of the one before.
- R5: A write to register 0, 2 or 4 makes `busy` rise at that clock edge. `busy` stays high for exactly NUM_EP edges after the last such write, and a write that comes during a walk starts the walk again.
- R6: The completion bit, which is status bit 0 and drives `irq`, is set on the edge where `busy` falls. It stays set until a write to register 3 with bit 0 at 1. If the set and the clear fall on the same edge, the set wins.
- R7: An endpoint whose region would push the total past RAM_WORDS (512) is reported as not realized and gets no region. Status bit 1 and `err` become 1 and stay set until a write to register 3 with bit 1 at 1. Endpoints after it are still placed if they fit.
- R8: `q_respond` is 1 only when the queried endpoint is realized and `dev_cfg` is 1. An endpoint that is not realized never responds.
- R9: After reset the masks, sizes, index and status are all zero, no endpoint is realized, and `busy` and `irq` are low. Status bit 2 reads back `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register written (0 realize, 1 index, 2 size, 3 status, 4 double-buffer) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register read |
| rd_data | output | 32 | Read data, combinational |
| dev_cfg | input | 1 | Device configured, allows token responses |
| q_ep | input | 5 | Endpoint queried |
| q_base | output | 9 | Base word of the queried endpoint |
| q_bufs | output | 2 | Buffer count of the queried endpoint |
| q_realized | output | 1 | Queried endpoint has a region |
| q_respond | output | 1 | Queried endpoint may answer tokens |
| busy | output | 1 | Allocation walk in progress |
| irq | output | 1 | Sticky completion bit |
| err | output | 1 | Sticky overflow bit |

## Verification
A fault in the walk counter or the restart logic shows up as a wrong `busy` or `irq` on the exact clock where the reference expects a change. It is caught within NUM_EP cycles of the triggering write. A wrong accumulator, footprint or fit decision does not show on `busy` or `irq`. It shows as a wrong `q_base`, `q_bufs` or `q_realized`, and these are swept over every endpoint once each walk has ended. Because the regions are contiguous, a wrong footprint for one endpoint moves the base of every realized endpoint above it, so one such fault usually fails many checks.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  typedef enum logic [2:0] {
    REG_REALIZE = 3'd0,
    REG_INDEX   = 3'd1,
    REG_SIZE    = 3'd2,
    REG_STATUS  = 3'd3,
    REG_DBUF    = 3'd4
  } reg_sel_e;

  // Words one endpoint needs: header plus packet rounded up, per buffer
  function automatic int unsigned ep_words(input int unsigned bytes, input logic dbl);
    int unsigned per_buf;
    per_buf = ((bytes + 32'd3) >> 2) + 32'd1;
    return dbl ? (per_buf << 1) : per_buf;
  endfunction
endpackage

// File: rtl/ep_alloc_regs.sv
module ep_alloc_regs
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned MPS_W  = 10,
  localparam int unsigned PW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              busy,
  input  logic              finish,
  input  logic              ovf_set,
  output logic [NUM_EP-1:0] realize,
  output logic [NUM_EP-1:0] dbuf,
  output logic [MPS_W-1:0]  mps [NUM_EP],
  output logic              start,
  output logic              done,
  output logic              err
);
  logic [PW-1:0] idx_q;
  logic          clr_done, clr_err;

  assign start    = wr_en && (wr_addr == REG_REALIZE || wr_addr == REG_SIZE || wr_addr == REG_DBUF);
  assign clr_done = wr_en && wr_addr == REG_STATUS && wr_data[0];
  assign clr_err  = wr_en && wr_addr == REG_STATUS && wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      realize <= '0;
      dbuf    <= '0;
      idx_q   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      for (int i = 0; i < NUM_EP; i++) mps[i] <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          REG_REALIZE: realize    <= wr_data[NUM_EP-1:0];
          REG_INDEX:   idx_q      <= wr_data[PW-1:0];
          REG_SIZE:    mps[idx_q] <= wr_data[MPS_W-1:0];
          REG_DBUF:    dbuf       <= wr_data[NUM_EP-1:0];
          default: ;
        endcase
      end
      if (finish)        done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (ovf_set)       err  <= 1'b1;
      else if (clr_err)  err  <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_REALIZE: rd_data = 32'(realize);
      REG_INDEX:   rd_data = 32'(idx_q);
      REG_SIZE:    rd_data = 32'(mps[idx_q]);
      REG_STATUS:  rd_data = {29'd0, busy, err, done};
      REG_DBUF:    rd_data = 32'(dbuf);
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ep_alloc_walker.sv
module ep_alloc_walker
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP    = 32,
  parameter int unsigned MPS_W     = 10,
  parameter int unsigned PTR_WORDS = 32,
  parameter int unsigned RAM_WORDS = 512,
  localparam int unsigned PW       = $clog2(NUM_EP),
  localparam int unsigned AW       = $clog2(RAM_WORDS),
  localparam int unsigned SW       = $clog2(RAM_WORDS + 2 * (((1 << MPS_W) + 3) / 4 + 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_EP-1:0] realize,
  input  logic [NUM_EP-1:0] dbuf,
  input  logic [MPS_W-1:0]  mps [NUM_EP],
  output logic              busy,
  output logic              finish,
  output logic              ovf_set,
  output logic [AW-1:0]     base [NUM_EP],
  output logic [NUM_EP-1:0] fit
);
  logic [PW-1:0] ptr;
  logic [SW-1:0] acc;
  int unsigned   cur_words, sum;
  logic          want, fits, last;

  always_comb begin
    want      = realize[ptr];
    cur_words = want ? ep_words(32'(mps[ptr]), dbuf[ptr]) : 32'd0;
    sum       = 32'(acc) + cur_words;
    fits      = sum <= RAM_WORDS;
    last      = ptr == PW'(NUM_EP - 1);
  end

  assign finish  = busy && last && !start;
  assign ovf_set = busy && !start && want && !fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      acc  <= '0;
      fit  <= '0;
      for (int i = 0; i < NUM_EP; i++) base[i] <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
      acc  <= SW'(PTR_WORDS);
    end else if (busy) begin
      fit[ptr]  <= want && fits;
      base[ptr] <= (want && fits) ? AW'(acc) : '0;
      if (want && fits) acc <= SW'(sum);
      if (last) busy <= 1'b0;
      else      ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ep_alloc.sv
module ep_alloc
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP    = 32,
  parameter int unsigned MPS_W     = 10,
  parameter int unsigned PTR_WORDS = 32,
  parameter int unsigned RAM_WORDS = 512,
  localparam int unsigned PW       = $clog2(NUM_EP),
  localparam int unsigned AW       = $clog2(RAM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  input  logic          dev_cfg,
  input  logic [PW-1:0] q_ep,
  output logic [AW-1:0] q_base,
  output logic [1:0]    q_bufs,
  output logic          q_realized,
  output logic          q_respond,
  output logic          busy,
  output logic          irq,
  output logic          err
);
  logic [NUM_EP-1:0] realize_q, dbuf_q, fit_q;
  logic [MPS_W-1:0]  mps_q [NUM_EP];
  logic [AW-1:0]     base_q [NUM_EP];
  logic              start, finish, ovf_set;

  ep_alloc_regs #(.NUM_EP(NUM_EP), .MPS_W(MPS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .finish(finish), .ovf_set(ovf_set),
    .realize(realize_q), .dbuf(dbuf_q), .mps(mps_q), .start(start), .done(irq), .err(err)
  );

  ep_alloc_walker #(.NUM_EP(NUM_EP), .MPS_W(MPS_W), .PTR_WORDS(PTR_WORDS), .RAM_WORDS(RAM_WORDS)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .realize(realize_q), .dbuf(dbuf_q), .mps(mps_q),
    .busy(busy), .finish(finish), .ovf_set(ovf_set), .base(base_q), .fit(fit_q)
  );

  assign q_realized = fit_q[q_ep];
  assign q_base     = base_q[q_ep];
  assign q_bufs     = !fit_q[q_ep] ? 2'd0 : (dbuf_q[q_ep] ? 2'd2 : 2'd1);
  assign q_respond  = fit_q[q_ep] && dev_cfg;
endmodule

// File: rtl/ep_alloc_chk.sv
module ep_alloc_chk #(
  parameter int unsigned PTR_WORDS = 32,
  parameter int unsigned RAM_WORDS = 512,
  parameter int unsigned AW        = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [31:0]   wr_data,
  input logic          busy,
  input logic          irq,
  input logic          q_realized,
  input logic [AW-1:0] q_base,
  input logic          q_respond,
  input logic          realize_bit
);
  // R5: a walk never starts without a register write on the edge before
  p_walk_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R6: the walk ending always leaves the completion bit set
  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R6: completion bit only drops after an explicit clear
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(wr_en && wr_addr == 3'd3 && wr_data[0]) |=> irq);

  // R8: an endpoint not in the realize mask never answers tokens
  p_unrealized_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !realize_bit |-> !q_respond);

  // R4: a placed region starts above the pointer area and inside the RAM
  p_base_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && q_realized |-> (32'(q_base) >= PTR_WORDS) && (32'(q_base) < RAM_WORDS));
endmodule

bind ep_alloc ep_alloc_chk #(.PTR_WORDS(PTR_WORDS), .RAM_WORDS(RAM_WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .irq(irq), .q_realized(q_realized), .q_base(q_base),
  .q_respond(q_respond), .realize_bit(realize_q[q_ep])
);

// File: tb/tb_ep_alloc.sv
module tb_ep_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 32;
  localparam int PTR = 32;
  localparam int RAM = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        dev_cfg = 1'b0;
  logic [4:0]  q_ep = '0;
  logic [8:0]  q_base;
  logic [1:0]  q_bufs;
  logic        q_realized, q_respond, busy, irq, err;

  int n_tests = 0;
  int n_fail  = 0;

  ep_alloc dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dev_cfg(dev_cfg), .q_ep(q_ep), .q_base(q_base),
    .q_bufs(q_bufs), .q_realized(q_realized), .q_respond(q_respond), .busy(busy),
    .irq(irq), .err(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model
  bit [31:0] m_real, m_db;
  int        m_idx, m_cnt;
  int        m_mps [N];
  int        m_base [N];
  bit        m_fit [N];
  bit        m_done, m_err;

  function automatic int words(int b, bit d);
    int w;
    w = (b + 3) / 4 + 1;
    return d ? 2 * w : w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_real = 0; m_db = 0; m_idx = 0; m_cnt = 0; m_done = 0; m_err = 0;
      for (int i = 0; i < N; i++) begin m_mps[i] = 0; m_base[i] = 0; m_fit[i] = 0; end
    end else begin
      bit trig, fin;
      int used;
      trig = wr_en && (wr_addr == 0 || wr_addr == 2 || wr_addr == 4);
      fin  = (m_cnt == 1) && !trig;
      if (wr_en) begin
        case (wr_addr)
          0: m_real = wr_data;
          1: m_idx = int'(wr_data[4:0]);
          2: m_mps[m_idx] = int'(wr_data[9:0]);
          3: begin
               if (wr_data[0]) m_done = 0;
               if (wr_data[1]) m_err = 0;
             end
          4: m_db = wr_data;
          default: ;
        endcase
      end
      if (trig) m_cnt = N;
      else if (m_cnt > 0) m_cnt--;
      if (fin) begin
        used = PTR;
        for (int i = 0; i < N; i++) begin
          m_fit[i] = 0; m_base[i] = 0;
          if (m_real[i]) begin
            if (used + words(m_mps[i], m_db[i]) <= RAM) begin
              m_fit[i] = 1; m_base[i] = used; used += words(m_mps[i], m_db[i]);
            end else m_err = 1;
          end
        end
        m_done = 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6", int'(irq), int'(m_done));
      check("R5", int'(busy), int'(m_cnt != 0));
      if (m_cnt == 0) check("R7", int'(err), int'(m_err));
      case (rd_addr)
        3'd0: check("R1", int'(rd_data), int'(m_real));
        3'd1: check("R2", int'(rd_data), m_idx);
        3'd2: check("R2", int'(rd_data), m_mps[m_idx]);
        3'd3: if (m_cnt == 0) check("R9", int'(rd_data), int'(m_done) | (int'(m_err) << 1));
        3'd4: check("R3", int'(rd_data), int'(m_db));
        default: ;
      endcase
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 500) begin @(negedge clk); t++; end
    if (t >= 500) check("R5 watchdog", 1, 0);
  endtask

  task automatic sweep();
    for (int e = 0; e < N; e++) begin
      q_ep = 5'(e);
      #1;
      check("R4", int'(q_base), m_base[e]);
      check("R3", int'(q_bufs), m_fit[e] ? (m_db[e] ? 2 : 1) : 0);
      check("R7", int'(q_realized), int'(m_fit[e]));
      check("R8", int'(q_respond), int'(m_fit[e] && dev_cfg));
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", int'(busy), 0);
    check("R9", int'(irq), 0);
    sweep();

    // Single endpoint, single buffer: base 32
    wr(1, 0); wr(2, 64); wr(0, 1);
    wait_idle(); sweep();
    check("R4", int'(dut.q_base), int'(q_base));

    // R1 read-OR-write adds endpoint 3 double buffered
    rd_addr = 3'd0; #1; v = int'(rd_data);
    wr(1, 3); wr(2, 8); wr(4, 32'h8); wr(0, v | 8);
    wait_idle(); sweep();
    rd_addr = 3'd0; #1;
    check("R1", int'(rd_data), 9);
    q_ep = 5'd3; #1;
    check("R4", int'(q_base), 49);

    // R6 clear completion
    wr(3, 1);
    check("R6", int'(irq), 0);

    // R2 size change for endpoint 0 only, shifts endpoint 3
    rd_addr = 3'd2;
    wr(1, 0); wr(2, 100);
    wait_idle(); sweep();
    q_ep = 5'd3; #1;
    check("R4", int'(q_base), 58);

    // R5 restart: trigger again mid-walk
    wr(1, 4); wr(2, 512);
    repeat (5) @(negedge clk);
    wr(1, 5); wr(2, 512);
    wr(1, 6); wr(2, 512);
    wr(1, 7); wr(2, 512);
    wr(1, 8); wr(2, 8);
    wait_idle();

    // R7 overflow: endpoint 7 does not fit, endpoint 8 still placed
    rd_addr = 3'd3;
    wr(0, 32'h1F9);
    wait_idle(); sweep();
    check("R7", int'(err), 1);
    q_ep = 5'd7; #1;
    check("R7", int'(q_realized), 0);
    q_ep = 5'd8; #1;
    check("R7", int'(q_realized), 1);

    // R8 token response gated by configuration
    dev_cfg = 1'b1;
    sweep();
    wr(3, 2);
    check("R7", int'(err), 0);
    wr(0, 0);
    wait_idle(); sweep();

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("[TB] FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule